// File: doc/BRIEF.md
# I2C Target Engine with Host-Released Clock Stretching

This block is a 7-bit addressed target (slave) for a two-wire I2C bus. It runs on the system clock. SCL and SDA pass through synchronizer chains, and Start, Stop and clock edges are recognised from the synchronized copies. The block pulls the lines low through two open-drain enables. A single byte register is shared by both directions: received bytes land in it, and a host write to it also primes the transmit shifter.

When a write is addressed to it, the engine acknowledges the address and each data byte. It refuses a byte that arrives while the previous one is still unread or while an overflow is still flagged. When a read is addressed to it, the engine always holds SCL low after the address. It releases SCL only when the host has supplied a byte and pulses the release input. It then shifts the byte out MSB first and waits again if the bus host acknowledges. The host side sees a buffer-full flag, a sticky overflow flag, a direction flag and an interrupt flag.

Top module: `i2c_stretch_slave`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `buf_full`, `overflow`, `rw_flag` and `irq` are all 0 and both bus lines are left released.
- R2: An address byte whose upper 7 bits equal `own_addr` and whose bit 0 is 0 (write) is acknowledged by holding SDA low during the ninth clock. It clears `rw_flag`, places the whole address byte in `rdata` and sets `buf_full`.
- R3: Each data byte of an accepted write is acknowledged and placed in `rdata`, with `buf_full` set. A `host_rd` pulse clears `buf_full`. If a byte is loaded in the same cycle as `host_rd`, the load wins.
- R4: A write-direction byte (address or data) arriving while `buf_full` or `overflow` is 1 gets no acknowledge (SDA stays high on the ninth clock), and `rdata` is left unchanged. `overflow` is set if `buf_full` was 1 at that time. `overflow` clears only on `host_ovf_clr`.
- R5: `irq` is set once for every byte handled for this target. It stays set until `host_irq_clr`, and a set in the same cycle as a clear wins.
- R6: With `stretch_en` = 1, `scl_oe` is asserted after the ninth falling SCL edge of each accepted data byte and stays asserted until `host_release`. With `stretch_en` = 0, no stretch follows a received data byte.
- R7: A matching address byte with bit 0 = 1 (read) is acknowledged and sets `rw_flag`. SCL is then held low regardless of `stretch_en`.
- R8: `host_wr` loads the byte that is transmitted after the next release. Bits leave MSB first, and SDA changes only while SCL is low.
- R9: The bus host's ninth-bit response is sampled on the ninth rising SCL edge. On acknowledge (SDA low), `irq` is set on the ninth falling edge and SCL is held again. On no-acknowledge, `irq` is set, SCL is not held, and SDA stays released until the next Start.
- R10: An address byte that does not match `own_addr` is not acknowledged and changes no flag. SDA and SCL stay released until the next Start.
- R11: A Start (SDA falling while SCL high) or Stop (SDA rising while SCL high) abandons a partly received byte. After a Start, the next eight bits are matched as an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| own_addr | input | 7 | Address this target answers to |
| stretch_en | input | 1 | Hold SCL after each received data byte |
| host_wr | input | 1 | Pulse: write `host_wdata` to the byte register and transmit shifter |
| host_wdata | input | 8 | Data for `host_wr` |
| host_rd | input | 1 | Pulse: host has read `rdata`, clears `buf_full` |
| host_irq_clr | input | 1 | Pulse: clear `irq` |
| host_ovf_clr | input | 1 | Pulse: clear `overflow` |
| host_release | input | 1 | Pulse: stop holding SCL |
| rdata | output | 8 | Byte register contents |
| buf_full | output | 1 | Unread received byte present |
| overflow | output | 1 | Byte refused while buffer was full |
| rw_flag | output | 1 | Direction of the last matched address, 1 = read |
| irq | output | 1 | Byte-event interrupt flag |

## Verification
The byte-load event from the bus engine can land in the same cycle as the host's buffer read, and the interrupt set can land in the same cycle as the host's interrupt clear. The bench provokes both by holding `host_rd` and `host_irq_clr` high for the whole duration of one received data byte. It then counts the cycles in which `buf_full` and `irq` are seen high. Exactly one cycle each shows that the load and the set won their collision cycle, and `rdata` must still carry the byte. Around this directed case, seeded random write and read transactions are checked against a bench model of the flags and acknowledge decisions.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ADDR,
      ST_RX,
      ST_TX
   } i2cs_state_t;

   // one-cycle events from the bus engine to the host-side flags
   typedef struct packed {
      logic load;        // received byte goes into the byte register
      logic refuse_full; // byte refused while buffer was full
      logic irq;         // byte event for the interrupt flag
      logic rw_set;      // read address matched
      logic rw_clr;      // write address matched
   } i2cs_ev_t;

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= RST_VAL;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/i2cs_linemon.sv
module i2cs_linemon #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);

   logic scl_d, sda_d;

   i2cs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s)
   );

   i2cs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   always_comb begin
      scl_rise = scl_s & ~scl_d;
      scl_fall = ~scl_s & scl_d;
      start_ev = scl_s & scl_d & sda_d & ~sda_s;
      stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
   end

endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
   import i2cs_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_ev,
   input  logic              stop_ev,
   input  logic              sda_s,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              stretch_en,
   input  logic              buf_full,
   input  logic              overflow,
   input  logic              tx_load,
   input  logic [BYTE_W-1:0] tx_data,
   input  logic              release_req,
   output logic              sda_oe,
   output logic              scl_oe,
   output i2cs_ev_t          ev,
   output logic [BYTE_W-1:0] ev_data
);

   localparam int               CNT_W   = $clog2(BYTE_W + 2);
   localparam logic [CNT_W-1:0] CNT_ACK = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] CNT_END = CNT_W'(BYTE_W + 1);

   i2cs_state_t       st;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] shreg;
   logic [BYTE_W-1:0] txreg;
   logic [BYTE_W-1:0] txsh;
   logic              sda_q;
   logic              hold_q;
   logic              dir_rd;
   logic              mst_ack;
   logic              refuse;

   assign refuse = buf_full | overflow;
   assign sda_oe = sda_q;
   assign scl_oe = hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cnt     <= '0;
         shreg   <= '0;
         txreg   <= '0;
         txsh    <= '0;
         sda_q   <= 1'b0;
         hold_q  <= 1'b0;
         dir_rd  <= 1'b0;
         mst_ack <= 1'b0;
         ev      <= '0;
         ev_data <= '0;
      end else begin
         ev <= '0;
         if (tx_load) txreg <= tx_data;

         if (start_ev) begin
            st     <= ST_ADDR;
            cnt    <= '0;
            sda_q  <= 1'b0;
            hold_q <= 1'b0;
         end else if (stop_ev) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            sda_q  <= 1'b0;
            hold_q <= 1'b0;
         end else begin
            // host frees the clock; a transmit byte presents its MSB now
            if (hold_q && release_req) begin
               hold_q <= 1'b0;
               if (st == ST_TX) begin
                  sda_q <= ~txreg[BYTE_W-1];
                  txsh  <= {txreg[BYTE_W-2:0], 1'b0};
               end
            end

            if (st != ST_IDLE && scl_rise) begin
               if (cnt < CNT_ACK) shreg <= {shreg[BYTE_W-2:0], sda_s};
               if (cnt == CNT_ACK && st == ST_TX) mst_ack <= ~sda_s;
               cnt <= cnt + 1'b1;
            end

            if (scl_fall) begin
               unique case (st)
                  ST_ADDR: begin
                     if (cnt == CNT_ACK) begin
                        if (shreg[BYTE_W-1:1] != own_addr) begin
                           st <= ST_IDLE;
                        end else if (shreg[0]) begin
                           ev.load   <= 1'b1;
                           ev.irq    <= 1'b1;
                           ev.rw_set <= 1'b1;
                           ev_data   <= shreg;
                           sda_q     <= 1'b1;
                           dir_rd    <= 1'b1;
                        end else if (refuse) begin
                           ev.refuse_full <= buf_full;
                           ev.irq         <= 1'b1;
                           st             <= ST_IDLE;
                        end else begin
                           ev.load   <= 1'b1;
                           ev.irq    <= 1'b1;
                           ev.rw_clr <= 1'b1;
                           ev_data   <= shreg;
                           sda_q     <= 1'b1;
                           dir_rd    <= 1'b0;
                        end
                     end else if (cnt == CNT_END) begin
                        sda_q <= 1'b0;
                        cnt   <= '0;
                        if (dir_rd) begin
                           st     <= ST_TX;
                           hold_q <= 1'b1;
                        end else begin
                           st <= ST_RX;
                        end
                     end
                  end
                  ST_RX: begin
                     if (cnt == CNT_ACK) begin
                        if (refuse) begin
                           ev.refuse_full <= buf_full;
                           ev.irq         <= 1'b1;
                           st             <= ST_IDLE;
                        end else begin
                           ev.load <= 1'b1;
                           ev.irq  <= 1'b1;
                           ev_data <= shreg;
                           sda_q   <= 1'b1;
                        end
                     end else if (cnt == CNT_END) begin
                        sda_q  <= 1'b0;
                        cnt    <= '0;
                        hold_q <= stretch_en;
                     end
                  end
                  ST_TX: begin
                     if (cnt == CNT_END) begin
                        ev.irq <= 1'b1;
                        cnt    <= '0;
                        if (mst_ack) hold_q <= 1'b1;
                        else         st     <= ST_IDLE;
                     end else if (cnt == CNT_ACK) begin
                        sda_q <= 1'b0;
                     end else if (cnt != '0) begin
                        sda_q <= ~txsh[BYTE_W-1];
                        txsh  <= {txsh[BYTE_W-2:0], 1'b0};
                     end
                  end
                  default: ;
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/i2cs_hostregs.sv
module i2cs_hostregs
   import i2cs_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  i2cs_ev_t          ev,
   input  logic [BYTE_W-1:0] ev_data,
   input  logic              host_wr,
   input  logic [BYTE_W-1:0] host_wdata,
   input  logic              host_rd,
   input  logic              host_irq_clr,
   input  logic              host_ovf_clr,
   output logic [BYTE_W-1:0] rdata,
   output logic              buf_full,
   output logic              overflow,
   output logic              rw_flag,
   output logic              irq
);

   // engine events take priority over host actions in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata    <= '0;
         buf_full <= 1'b0;
         overflow <= 1'b0;
         rw_flag  <= 1'b0;
         irq      <= 1'b0;
      end else begin
         if (ev.load)      rdata <= ev_data;
         else if (host_wr) rdata <= host_wdata;

         if (ev.load)      buf_full <= 1'b1;
         else if (host_rd) buf_full <= 1'b0;

         if (ev.refuse_full) overflow <= 1'b1;
         else if (host_ovf_clr) overflow <= 1'b0;

         if (ev.rw_set)      rw_flag <= 1'b1;
         else if (ev.rw_clr) rw_flag <= 1'b0;

         if (ev.irq)           irq <= 1'b1;
         else if (host_irq_clr) irq <= 1'b0;
      end
   end

endmodule

// File: rtl/i2c_stretch_slave.sv
module i2c_stretch_slave
   import i2cs_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int ADDR_W      = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_oe,
   output logic              sda_oe,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              stretch_en,
   input  logic              host_wr,
   input  logic [BYTE_W-1:0] host_wdata,
   input  logic              host_rd,
   input  logic              host_irq_clr,
   input  logic              host_ovf_clr,
   input  logic              host_release,
   output logic [BYTE_W-1:0] rdata,
   output logic              buf_full,
   output logic              overflow,
   output logic              rw_flag,
   output logic              irq
);

   generate
      if (ADDR_W != BYTE_W - 1) begin : g_bad_addr_w
         $error("ADDR_W must be BYTE_W-1 for 7-bit style addressing");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (BYTE_W < 2) begin : g_bad_byte
         $error("BYTE_W must be at least 2");
      end
   endgenerate

   logic              ln_scl_s, ln_sda_s, ln_rise, ln_fall, ln_start, ln_stop;
   i2cs_ev_t          eng_ev;
   logic [BYTE_W-1:0] eng_data;
   logic              ev_load_w, ev_refuse_w;

   assign ev_load_w   = eng_ev.load;
   assign ev_refuse_w = eng_ev.refuse_full;

   i2cs_linemon #(.SYNC_STAGES(SYNC_STAGES)) u_lines (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .scl_s    (ln_scl_s),
      .sda_s    (ln_sda_s),
      .scl_rise (ln_rise),
      .scl_fall (ln_fall),
      .start_ev (ln_start),
      .stop_ev  (ln_stop)
   );

   i2cs_engine #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_engine (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_rise    (ln_rise),
      .scl_fall    (ln_fall),
      .start_ev    (ln_start),
      .stop_ev     (ln_stop),
      .sda_s       (ln_sda_s),
      .own_addr    (own_addr),
      .stretch_en  (stretch_en),
      .buf_full    (buf_full),
      .overflow    (overflow),
      .tx_load     (host_wr),
      .tx_data     (host_wdata),
      .release_req (host_release),
      .sda_oe      (sda_oe),
      .scl_oe      (scl_oe),
      .ev          (eng_ev),
      .ev_data     (eng_data)
   );

   i2cs_hostregs #(.BYTE_W(BYTE_W)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .ev           (eng_ev),
      .ev_data      (eng_data),
      .host_wr      (host_wr),
      .host_wdata   (host_wdata),
      .host_rd      (host_rd),
      .host_irq_clr (host_irq_clr),
      .host_ovf_clr (host_ovf_clr),
      .rdata        (rdata),
      .buf_full     (buf_full),
      .overflow     (overflow),
      .rw_flag      (rw_flag),
      .irq          (irq)
   );

endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_s,
   input logic start_ev,
   input logic stop_ev,
   input logic sda_oe,
   input logic scl_oe,
   input logic host_release,
   input logic host_rd,
   input logic host_irq_clr,
   input logic host_ovf_clr,
   input logic ev_load,
   input logic ev_refuse,
   input logic buf_full,
   input logic overflow,
   input logic irq
);

   // R8
   sda_pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !$past(scl_s));

   // R6
   scl_hold_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_oe) |-> !$past(scl_s));

   // R6
   scl_free_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scl_oe) |-> ($past(host_release) || $past(start_ev) || $past(stop_ev)));

   // R4
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_refuse |=> overflow);

   // R4
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !host_ovf_clr) |=> overflow);

   // R5
   irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !host_irq_clr) |=> irq);

   // R3
   rd_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !ev_load) |=> !buf_full);

   // R3
   load_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_load |=> buf_full);

endmodule

bind i2c_stretch_slave i2cs_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .scl_s        (ln_scl_s),
   .start_ev     (ln_start),
   .stop_ev      (ln_stop),
   .sda_oe       (sda_oe),
   .scl_oe       (scl_oe),
   .host_release (host_release),
   .host_rd      (host_rd),
   .host_irq_clr (host_irq_clr),
   .host_ovf_clr (host_ovf_clr),
   .ev_load      (ev_load_w),
   .ev_refuse    (ev_refuse_w),
   .buf_full     (buf_full),
   .overflow     (overflow),
   .irq          (irq)
);

// File: tb/i2c_stretch_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_stretch_slave_tb_top;

   localparam int Q = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl_low = 1'b0;
   logic       m_sda_low = 1'b0;
   logic       scl_oe, sda_oe;
   logic [6:0] own_addr = 7'h00;
   logic       stretch_en = 1'b0;
   logic       host_wr = 1'b0;
   logic [7:0] host_wdata = 8'h00;
   logic       host_rd = 1'b0;
   logic       host_irq_clr = 1'b0;
   logic       host_ovf_clr = 1'b0;
   logic       host_release = 1'b0;
   logic [7:0] rdata;
   logic       buf_full, overflow, rw_flag, irq;

   wire scl_line = ~(m_scl_low | scl_oe);
   wire sda_line = ~(m_sda_low | sda_oe);

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   bit mon_en = 1'b0;
   int n_full_hi = 0;
   int n_irq_hi = 0;

   always #4 clk = ~clk;

   i2c_stretch_slave dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr),
      .stretch_en(stretch_en), .host_wr(host_wr), .host_wdata(host_wdata),
      .host_rd(host_rd), .host_irq_clr(host_irq_clr),
      .host_ovf_clr(host_ovf_clr), .host_release(host_release),
      .rdata(rdata), .buf_full(buf_full), .overflow(overflow),
      .rw_flag(rw_flag), .irq(irq)
   );

   always @(negedge clk) begin
      if (mon_en) begin
         if (buf_full) n_full_hi++;
         if (irq)      n_irq_hi++;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] addr_byte(input logic [6:0] a, input logic rd);
      return {a, rd};
   endfunction

   function automatic logic exp_accept(input logic full, input logic ovf);
      return !(full || ovf);
   endfunction

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   // ---------------- host side ----------------
   task automatic pulse_rd();
      @(negedge clk) host_rd = 1'b1;
      @(negedge clk) host_rd = 1'b0;
      @(negedge clk);
   endtask
   task automatic pulse_irq_clr();
      @(negedge clk) host_irq_clr = 1'b1;
      @(negedge clk) host_irq_clr = 1'b0;
      @(negedge clk);
   endtask
   task automatic pulse_ovf_clr();
      @(negedge clk) host_ovf_clr = 1'b1;
      @(negedge clk) host_ovf_clr = 1'b0;
      @(negedge clk);
   endtask
   task automatic pulse_release();
      @(negedge clk) host_release = 1'b1;
      @(negedge clk) host_release = 1'b0;
      @(negedge clk);
   endtask
   task automatic host_write(input logic [7:0] d);
      @(negedge clk) begin host_wr = 1'b1; host_wdata = d; end
      @(negedge clk) host_wr = 1'b0;
      @(negedge clk);
   endtask

   // ---------------- bus host model ----------------
   task automatic wait_q();
      repeat (Q) @(negedge clk);
   endtask
   task automatic clk_high();
      m_scl_low = 1'b0;
      while (scl_line !== 1'b1) @(negedge clk);
      wait_q();
   endtask
   task automatic clk_low();
      m_scl_low = 1'b1;
      wait_q();
   endtask
   task automatic m_start();
      m_sda_low = 1'b0;
      wait_q();
      clk_high();
      m_sda_low = 1'b1;
      wait_q();
      clk_low();
   endtask
   task automatic m_stop();
      m_sda_low = 1'b1;
      wait_q();
      clk_high();
      m_sda_low = 1'b0;
      wait_q();
   endtask
   task automatic m_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         m_sda_low = ~b[i];
         wait_q();
         clk_high();
         clk_low();
      end
   endtask
   task automatic m_send(input logic [7:0] b, output logic ack);
      m_bits(b, 8);
      m_sda_low = 1'b0;
      wait_q();
      clk_high();
      ack = (sda_line == 1'b0);
      clk_low();
   endtask
   task automatic m_recv(input logic give_ack, output logic [7:0] b);
      m_sda_low = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         wait_q();
         clk_high();
         b[i] = sda_line;
         clk_low();
      end
      m_sda_low = give_ack;
      wait_q();
      clk_high();
      clk_low();
      m_sda_low = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         summary();
      end
   end

   initial begin
      logic       ack;
      logic [7:0] d, got;
      logic [6:0] other;
      int unsigned seed_v;
      seed_v = $urandom(32'd20240611);
      own_addr = 7'($urandom_range(1, 126));
      other = own_addr ^ 7'h2B;

      repeat (5) @(negedge clk);
      // R1 reset state
      chk("R1 scl_oe", 32'(scl_oe), 0);
      chk("R1 sda_oe", 32'(sda_oe), 0);
      chk("R1 flags", {28'd0, buf_full, overflow, rw_flag, irq}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R1 flags after release", {28'd0, buf_full, overflow, rw_flag, irq}, 0);

      // R10 mismatched address is ignored
      m_start();
      m_send(addr_byte(other, 1'b0), ack);
      chk("R10 no ack", 32'(ack), 0);
      chk("R10 flags untouched", {28'd0, buf_full, overflow, rw_flag, irq}, 0);
      m_send(addr_byte(own_addr, 1'b0), ack);
      chk("R10 ignored until start", 32'(ack), 0);
      chk("R10 scl free", 32'(scl_oe), 0);
      m_stop();

      // R11 abandoned partial byte then repeated start
      m_start();
      m_bits(8'hA5, 4);
      m_start();
      chk("R11 no irq from partial", 32'(irq), 0);
      m_send(addr_byte(own_addr, 1'b0), ack);
      chk("R11 address after restart acked", 32'(ack), 1);
      pulse_rd();
      pulse_irq_clr();
      m_stop();

      // random mix of write and read transactions
      for (int t = 0; t < 6; t++) begin
         logic rd;
         int   n;
         rd = 1'($urandom_range(0, 1));
         n  = $urandom_range(1, 3);
         stretch_en = 1'($urandom_range(0, 1));
         m_start();
         m_send(addr_byte(own_addr, rd), ack);
         chk(rd ? "R7 read addr ack" : "R2 write addr ack", 32'(ack), 1);
         chk(rd ? "R7 rw_flag" : "R2 rw_flag", 32'(rw_flag), 32'(rd));
         chk("R2 addr byte in buffer", 32'(rdata), 32'(addr_byte(own_addr, rd)));
         chk("R5 irq on address", 32'(irq), 1);
         if (rd) chk("R7 scl held after read addr", 32'(scl_oe), 1);
         else    chk("R2 no stretch after write addr", 32'(scl_oe), 0);
         pulse_rd();
         pulse_irq_clr();
         chk("R5 irq cleared", 32'(irq), 0);
         for (int k = 0; k < n; k++) begin
            logic last;
            last = (k == n - 1);
            d = 8'($urandom);
            if (!rd) begin
               m_send(d, ack);
               chk("R3 data ack", 32'(ack), 32'(exp_accept(1'b0, 1'b0)));
               chk("R3 data in buffer", 32'(rdata), 32'(d));
               chk("R3 buf_full", 32'(buf_full), 1);
               chk("R5 irq per byte", 32'(irq), 1);
               chk("R6 stretch follows stretch_en", 32'(scl_oe), 32'(stretch_en));
               pulse_rd();
               chk("R3 host read clears full", 32'(buf_full), 0);
               pulse_irq_clr();
               pulse_release();
               chk("R6 released", 32'(scl_oe), 0);
            end else begin
               host_write(d);
               chk("R6 still held before release", 32'(scl_oe), 1);
               pulse_release();
               m_recv(!last, got);
               chk("R8 transmitted byte", 32'(got), 32'(d));
               chk("R9 irq after ninth clock", 32'(irq), 1);
               chk("R9 hold follows host ack", 32'(scl_oe), 32'(!last));
               pulse_irq_clr();
               if (last) begin
                  m_recv(1'b0, got);
                  chk("R9 idle after nack", 32'(got), 32'hFF);
               end
            end
         end
         m_stop();
         if (rd) begin
            pulse_rd();
            chk("R9 no irq while idle", 32'(irq), 0);
         end
      end

      // R4 overflow sequence
      stretch_en = 1'b0;
      m_start();
      m_send(addr_byte(own_addr, 1'b0), ack);
      chk("R4 addr accepted", 32'(ack), 1);
      d = 8'($urandom);
      m_send(d, ack);
      chk("R4 nack when full", 32'(ack), 0);
      chk("R4 overflow set", 32'(overflow), 1);
      chk("R4 buffer unchanged", 32'(rdata), 32'(addr_byte(own_addr, 1'b0)));
      m_stop();
      pulse_rd();
      pulse_irq_clr();
      chk("R4 overflow survives read", 32'(overflow), 1);
      m_start();
      m_send(addr_byte(own_addr, 1'b0), ack);
      chk("R4 nack while overflow flagged", 32'(ack), 32'(exp_accept(buf_full, 1'b1)));
      chk("R4 not loaded", 32'(buf_full), 0);
      m_stop();
      pulse_ovf_clr();
      chk("R4 overflow cleared", 32'(overflow), 0);
      pulse_irq_clr();

      // R3 / R5 collision: byte load and irq set against held host clears
      m_start();
      m_send(addr_byte(own_addr, 1'b0), ack);
      chk("R2 addr ack before collision", 32'(ack), 1);
      @(negedge clk) begin host_rd = 1'b1; host_irq_clr = 1'b1; end
      @(negedge clk) mon_en = 1'b1;
      d = 8'($urandom);
      m_send(d, ack);
      @(negedge clk) mon_en = 1'b0;
      host_rd = 1'b0;
      host_irq_clr = 1'b0;
      chk("R3 collision byte acked", 32'(ack), 1);
      chk("R3 load wins over host read", 32'(n_full_hi), 1);
      chk("R5 set wins over clear", 32'(n_irq_hi), 1);
      chk("R3 collision byte in buffer", 32'(rdata), 32'(d));
      m_stop();

      done = 1'b1;
      summary();
   end

endmodule